// File: doc/BRIEF.md
# Pipelined Move-Only Processor Core

This block is a small processor whose single instruction is a move. Each instruction word holds a source address and a destination address. The core does all arithmetic through two function addresses at the top of the address space. A store to the load address replaces the accumulator. A store to the sum address adds the moved value to the accumulator. A read of either address returns the accumulator. The core uses no indexing and no indirection.

Every instruction passes through three stages in order: instruction fetch, operand read from the source address, and store to the destination address. Under no hazard a new instruction enters each cycle. There is no bypass path, so hazards are resolved by stalling. An operand read stalls when it would read the address being stored in that cycle. It also stalls when the source and the destination are both function addresses, because a bypass would be wrong for them. Ordinary data addresses share one memory port, so a store and a read that both need the port cost the read one cycle. Function addresses are decoded inside the core and never use the port.

An all-zero instruction word halts the core. Fetch stops, the older instructions drain, and `done_o` rises. A test counter then holds the number of the cycle in which the last store happened.

Top module: `mv_core`

## Requirements
- R1: A move whose source and destination are ordinary addresses writes the source word to the destination through the data port (`dmem_we_o` high, `dmem_addr_o` equal to the destination).
- R2: A move to address 0xFFFF loads the accumulator with the moved value. A move from 0xFFFF returns the current accumulator.
- R3: A move to address 0xFFFE sets the accumulator to its old value plus the moved value, modulo 2^16. A read of 0xFFFE also returns the accumulator.
- R4: An instruction never stalls unless an older instruction is in the store stage. Moves with no hazard complete at one per cycle: a run of N moves finishes its last store in cycle N+2.
- R5: If the operand read's source equals the address being stored in the same cycle, the read stalls one cycle and then returns the newly stored value. The instruction being read is held unchanged during the stall.
- R6: If an operand read targets 0xFFFE or 0xFFFF while the store stage writes 0xFFFE or 0xFFFF, the read stalls one cycle. No stored value is ever bypassed into it.
- R7: If the store stage writes an ordinary address while the operand read needs an ordinary address, the read and fetch stall one cycle. Accesses to 0xFFFE and 0xFFFF never occupy the data port. A run of N ordinary-to-ordinary moves therefore finishes in cycle 2N+1.
- R8: The program "0xFFFF=a; 0xFFFE+=b; c=acc; 0xFFFE+=d; e=acc; halt" leaves c=a+b and e=a+b+d, and it finishes its last store in cycle 10.
- R9: An instruction word of zero (source 0, destination 0) is not executed and stops fetch. When the pipeline is empty, `done_o` rises and `cycle_o` freezes at the cycle of the last store, or at 1 if the halt is the first word.
- R10: While reset is held, and in the first cycle after it, `done_o` is 0, `cycle_o` is 0 and `dmem_we_o` is 0. Reset clears the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | PW | Instruction word address (program counter) |
| imem_data_i | input | 2*AW | Instruction word: source in the upper half, destination in the lower half, combinational read |
| dmem_addr_o | output | AW | Data port address, used for the store when one is pending, otherwise for the read |
| dmem_we_o | output | 1 | Data port write enable |
| dmem_wdata_o | output | DW | Data port write value |
| dmem_rdata_i | input | DW | Data port read value, combinational |
| done_o | output | 1 | Halted and drained |
| cycle_o | output | CW | Cycle count since reset, frozen when done |

## Verification
The bench builds the core with its default parameters: 16-bit addresses and data, an 8-bit program counter and a 16-bit cycle counter. The 16-bit data width makes the accumulator wrap reachable with a single add of 2 to 0xFFFF. The fixed function addresses 0xFFFE and 0xFFFF let short programs on low data addresses exercise every hazard kind. Because the counter freezes at the cycle of the last store, each program's exact schedule can be compared with a count worked out by hand.

// File: rtl/mv_pkg.sv
package mv_pkg;

  typedef enum logic [1:0] {
    SEL_MEM = 2'd0,
    SEL_ACC = 2'd1,
    SEL_ADD = 2'd2
  } sel_e;

  function automatic logic is_fn(sel_e s);
    return s != SEL_MEM;
  endfunction

endpackage

// File: rtl/mv_addr_dec.sv
module mv_addr_dec
  import mv_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  output sel_e          sel_o
);

  localparam logic [AW-1:0] ACC_A = '1;
  localparam logic [AW-1:0] ADD_A = ACC_A - 1'b1;

  always_comb begin
    if (addr_i == ACC_A)      sel_o = SEL_ACC;
    else if (addr_i == ADD_A) sel_o = SEL_ADD;
    else                      sel_o = SEL_MEM;
  end

endmodule

// File: rtl/mv_fetch.sv
module mv_fetch #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic [2*AW-1:0] instr_i,
  output logic [PW-1:0] pc_o,
  output logic          of_v_o,
  output logic [AW-1:0] of_src_o,
  output logic [AW-1:0] of_dst_o,
  output logic          of_v_nxt_o,
  output logic          halt_nxt_o
);

  logic [PW-1:0] pc_q, pc_d;
  logic          halt_q, halt_d;
  logic          ofv_q, ofv_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic          is_halt;

  assign is_halt = (instr_i == '0);

  always_comb begin
    pc_d   = pc_q;
    halt_d = halt_q;
    ofv_d  = ofv_q;
    src_d  = src_q;
    dst_d  = dst_q;
    if (!stall_i) begin
      if (halt_q) begin
        ofv_d = 1'b0;
      end else if (is_halt) begin
        halt_d = 1'b1;
        ofv_d  = 1'b0;
      end else begin
        ofv_d = 1'b1;
        src_d = instr_i[2*AW-1:AW];
        dst_d = instr_i[AW-1:0];
        pc_d  = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
      ofv_q  <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      pc_q   <= pc_d;
      halt_q <= halt_d;
      ofv_q  <= ofv_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
    end
  end

  assign pc_o       = pc_q;
  assign of_v_o     = ofv_q;
  assign of_src_o   = src_q;
  assign of_dst_o   = dst_q;
  assign of_v_nxt_o = ofv_d;
  assign halt_nxt_o = halt_d;

endmodule

// File: rtl/mv_hazard.sv
module mv_hazard
  import mv_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          of_v_i,
  input  logic          os_v_i,
  input  logic [AW-1:0] of_src_i,
  input  logic [AW-1:0] os_dst_i,
  input  sel_e          src_sel_i,
  input  sel_e          dst_sel_i,
  output logic          stall_o
);

  logic both_live, raw_hit, fn_hit, port_hit;

  assign both_live = of_v_i && os_v_i;
  // same address: wait for the store to land
  assign raw_hit   = both_live && (of_src_i == os_dst_i);
  // function registers: never bypass, always wait
  assign fn_hit    = both_live && is_fn(src_sel_i) && is_fn(dst_sel_i);
  // one data port shared by store and read
  assign port_hit  = both_live && !is_fn(src_sel_i) && !is_fn(dst_sel_i);

  assign stall_o = raw_hit || fn_hit || port_hit;

endmodule

// File: rtl/mv_acc.sv
module mv_acc #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          add_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] acc_o
);

  logic [DW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (wr_i)  acc_q <= add_i ? acc_q + data_i : data_i;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/mv_core.sv
module mv_core
  import mv_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int PW = 8,
  parameter int CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PW-1:0]   imem_addr_o,
  input  logic [2*AW-1:0] imem_data_i,
  output logic [AW-1:0]   dmem_addr_o,
  output logic            dmem_we_o,
  output logic [DW-1:0]   dmem_wdata_o,
  input  logic [DW-1:0]   dmem_rdata_i,
  output logic            done_o,
  output logic [CW-1:0]   cycle_o
);

  logic          of_v, of_v_nxt, halt_nxt, stall;
  logic [AW-1:0] of_src, of_dst;
  sel_e          src_sel, dst_sel;
  logic [DW-1:0] acc, of_data;

  logic          os_v_q;
  logic [AW-1:0] os_dst_q;
  logic [DW-1:0] os_data_q;
  logic          done_q, done_d;
  logic [CW-1:0] cyc_q;

  mv_fetch #(.AW(AW), .PW(PW)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall),
    .instr_i    (imem_data_i),
    .pc_o       (imem_addr_o),
    .of_v_o     (of_v),
    .of_src_o   (of_src),
    .of_dst_o   (of_dst),
    .of_v_nxt_o (of_v_nxt),
    .halt_nxt_o (halt_nxt)
  );

  mv_addr_dec #(.AW(AW)) u_src_dec (.addr_i(of_src),   .sel_o(src_sel));
  mv_addr_dec #(.AW(AW)) u_dst_dec (.addr_i(os_dst_q), .sel_o(dst_sel));

  mv_hazard #(.AW(AW)) u_haz (
    .of_v_i    (of_v),
    .os_v_i    (os_v_q),
    .of_src_i  (of_src),
    .os_dst_i  (os_dst_q),
    .src_sel_i (src_sel),
    .dst_sel_i (dst_sel),
    .stall_o   (stall)
  );

  mv_acc #(.DW(DW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (os_v_q && is_fn(dst_sel)),
    .add_i  (dst_sel == SEL_ADD),
    .data_i (os_data_q),
    .acc_o  (acc)
  );

  assign of_data = is_fn(src_sel) ? acc : dmem_rdata_i;

  // store owns the port when it targets ordinary memory
  assign dmem_we_o    = os_v_q && !is_fn(dst_sel);
  assign dmem_addr_o  = dmem_we_o ? os_dst_q : of_src;
  assign dmem_wdata_o = os_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      os_v_q    <= 1'b0;
      os_dst_q  <= '0;
      os_data_q <= '0;
    end else begin
      os_v_q <= of_v && !stall;
      if (of_v && !stall) begin
        os_dst_q  <= of_dst;
        os_data_q <= of_data;
      end
    end
  end

  assign done_d = halt_nxt && !of_v_nxt && !(of_v && !stall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      cyc_q  <= '0;
    end else if (!done_q) begin
      done_q <= done_d;
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  assign done_o  = done_q;
  assign cycle_o = cyc_q;

endmodule

// File: rtl/mv_core_chk.sv
module mv_core_chk
  import mv_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          of_v_i,
  input logic [AW-1:0] of_src_i,
  input logic          os_v_i,
  input logic [AW-1:0] os_dst_i,
  input logic [DW-1:0] os_data_i,
  input sel_e          src_sel_i,
  input sel_e          dst_sel_i,
  input logic          stall_i,
  input logic [DW-1:0] acc_i,
  input logic          dmem_we_i,
  input logic [AW-1:0] dmem_addr_i,
  input logic          done_i,
  input logic [CW-1:0] cycle_i
);

  localparam logic [AW-1:0] ACC_A = '1;
  localparam logic [AW-1:0] ADD_A = ACC_A - 1'b1;

  // R5
  raw_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_v_i && os_v_i && (of_src_i == os_dst_i) |-> stall_i);

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> of_v_i && $stable(of_src_i));

  // R6
  fn_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_v_i && os_v_i && src_sel_i != SEL_MEM && dst_sel_i != SEL_MEM |-> stall_i);

  // R7
  port_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_v_i && os_v_i && src_sel_i == SEL_MEM && dst_sel_i == SEL_MEM |-> stall_i);

  // R7
  fn_off_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_i |-> dmem_addr_i != ACC_A && dmem_addr_i != ADD_A);

  // R4
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> of_v_i && os_v_i);

  // R2
  acc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_v_i && dst_sel_i == SEL_ACC |=> acc_i == $past(os_data_i));

  // R3
  acc_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_v_i && dst_sel_i == SEL_ADD |=> acc_i == DW'($past(acc_i) + $past(os_data_i)));

  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i && $stable(cycle_i));

endmodule

bind mv_core mv_core_chk #(.AW(AW), .DW(DW), .CW(CW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .of_v_i      (of_v),
  .of_src_i    (of_src),
  .os_v_i      (os_v_q),
  .os_dst_i    (os_dst_q),
  .os_data_i   (os_data_q),
  .src_sel_i   (src_sel),
  .dst_sel_i   (dst_sel),
  .stall_i     (stall),
  .acc_i       (acc),
  .dmem_we_i   (dmem_we_o),
  .dmem_addr_i (dmem_addr_o),
  .done_i      (done_o),
  .cycle_i     (cycle_o)
);

// File: tb/test_mv_core.sv
module test_mv_core;

  localparam int CLK_P = 10;
  localparam logic [15:0] ACC = 16'hFFFF;
  localparam logic [15:0] ADD = 16'hFFFE;

  // a, b, d operand values for the accumulate program
  localparam logic [15:0] VEC [4][3] = '{
    '{16'h0001, 16'h0002, 16'h0003},
    '{16'h1234, 16'h0F0F, 16'h00FF},
    '{16'hFFFF, 16'h0002, 16'h0003},
    '{16'h8000, 16'h8000, 16'h7FFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [31:0] imem_data;
  logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, done;
  logic [15:0] cycle;

  logic [31:0] imem [0:63];
  logic [15:0] dmem [0:255];
  logic        ld_we = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  mv_core i_mv_core (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_we_o    (dmem_we),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .done_o       (done),
    .cycle_o      (cycle)
  );

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];

  always @(posedge clk) begin
    if (ld_we)        dmem[ld_a] <= ld_d;
    else if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) imem[i] = '0;
  endtask

  task automatic mv(input int idx, input logic [15:0] s, input logic [15:0] d);
    imem[idx] = {s, d};
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run(input string tag);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL %s: done never rose, got 0 expected 1", tag);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a, b, d;
    for (int i = 0; i < 64; i++) imem[i] = '0;
    for (int i = 0; i < 256; i++) dmem[i] = '0;

    // R10: reset state, then first cycle after release
    begin_prog();
    mv(0, 16'd10, 16'd20);
    poke(8'd10, 16'h5A5A);
    #1;
    check("R10 done in reset", done, 0);
    check("R10 cycle in reset", cycle, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 cycle after release", cycle, 0);
    check("R10 we after release", dmem_we, 0);
    check("R10 done after release", done, 0);

    // R8 R3 R2: accumulate program walked over the vector table
    for (int v = 0; v < 4; v++) begin
      a = VEC[v][0]; b = VEC[v][1]; d = VEC[v][2];
      begin_prog();
      mv(0, 16'd1, ACC);
      mv(1, 16'd2, ADD);
      mv(2, ACC, 16'd3);
      mv(3, 16'd4, ADD);
      mv(4, ACC, 16'd5);
      poke(8'd1, a); poke(8'd2, b); poke(8'd4, d);
      poke(8'd3, 16'hDEAD); poke(8'd5, 16'hBEEF);
      run("R8 table");
      check("R8 cycle of last store", cycle, 10);
      check("R3 c = a+b", dmem[3], 32'(16'(a + b)));
      check("R3 e = a+b+d", dmem[5], 32'(16'(a + b + d)));
    end

    // R4 R3: fn destinations never stall; final acc read stalls once (R6)
    begin_prog();
    mv(0, 16'd10, ACC);
    mv(1, 16'd11, ADD);
    mv(2, 16'd12, ADD);
    mv(3, ACC, 16'd20);
    poke(8'd10, 16'h0100); poke(8'd11, 16'h0020); poke(8'd12, 16'h0003);
    run("R4 fn stream");
    check("R4 cycles for fn stream", cycle, 7);
    check("R3 sum of three", dmem[20], 16'h0123);

    // R1 R5: read of just-stored address waits and sees new value
    begin_prog();
    mv(0, 16'd10, 16'd20);
    mv(1, 16'd20, 16'd21);
    poke(8'd10, 16'hC0DE); poke(8'd20, 16'h1111); poke(8'd21, 16'h2222);
    run("R5 raw");
    check("R5 cycles", cycle, 5);
    check("R1 first copy", dmem[20], 16'hC0DE);
    check("R5 forwarded by stall", dmem[21], 16'hC0DE);

    // R7: three ordinary moves, port conflict each pair -> 2N+1
    begin_prog();
    mv(0, 16'd10, 16'd30);
    mv(1, 16'd11, 16'd31);
    mv(2, 16'd12, 16'd32);
    poke(8'd10, 16'h00AA); poke(8'd11, 16'h00BB); poke(8'd12, 16'h00CC);
    run("R7 port");
    check("R7 cycles for 3 moves", cycle, 7);
    check("R1 move 1", dmem[30], 16'h00AA);
    check("R1 move 2", dmem[31], 16'h00BB);
    check("R1 move 3", dmem[32], 16'h00CC);

    // R6 R2: read acc right after load stalls once
    begin_prog();
    mv(0, 16'd10, ACC);
    mv(1, ACC, 16'd20);
    poke(8'd10, 16'h7777); poke(8'd20, 16'h0000);
    run("R6 acc after load");
    check("R6 cycles", cycle, 5);
    check("R2 acc readback", dmem[20], 16'h7777);

    // R3 R7: read of sum address gives acc; no stall beside ordinary store
    begin_prog();
    mv(0, 16'd10, ACC);
    mv(1, 16'd11, 16'd12);
    mv(2, ADD, 16'd20);
    poke(8'd10, 16'h4321); poke(8'd11, 16'h0055); poke(8'd20, 16'h0000);
    run("R7 fn read");
    check("R7 fn read uses no port", cycle, 5);
    check("R3 read of sum address", dmem[20], 16'h4321);
    check("R1 middle move", dmem[12], 16'h0055);

    // R9: halt as first word, counter freezes
    begin_prog();
    run("R9 halt first");
    check("R9 halt-only cycle", cycle, 1);
    repeat (5) @(negedge clk);
    check("R9 counter frozen", cycle, 1);
    check("R9 done held", done, 1);

    // R10: reset clears accumulator
    begin_prog();
    mv(0, ACC, 16'd20);
    poke(8'd20, 16'hFFFF);
    run("R10 acc clear");
    check("R10 acc cleared", dmem[20], 16'h0000);
    check("R10 single move cycles", cycle, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule